// File: doc/BRIEF.md
# Interrupt Request Collector for a Keypad Controller

This block gathers the interrupt sources of a keypad controller and drives one active-high interrupt request line to the host. It takes four kinds of source. The first is a new key event, given as a one-cycle pulse from the scanner. The second is an error condition, also a one-cycle pulse. The last two are general-purpose pins, and each of them can be enabled on its own as an external interrupt input. An enabled pin interrupts on every transition, rising or falling.

Every source has its own pending bit. The host reads these bits together as an interrupt code. A read strobe tells the block that the code has been taken, and all pending bits then clear at the next clock edge. Any source event that arrives in that same cycle survives the clear. A stay-awake output is high whenever something is pending or a source fires. Power control uses it to keep the device in active mode.

Top module: `irq_collector`

## Requirements
- R1: A one-cycle pulse on `key_evt_i` sets code bit 0 at the next clock edge, and `irq_o` is high from that edge onwards.
- R2: A one-cycle pulse on `err_evt_i` sets code bit 1 at the next clock edge, and `irq_o` is high from that edge onwards.
- R3: A rising transition on an enabled pin `gpio_i[i]` sets code bit 2+i. The bit becomes visible after the third rising clock edge that follows the transition (two synchronizer stages, then one edge-detect stage).
- R4: A falling transition on an enabled pin sets code bit 2+i with the same latency as R3.
- R5: A pin whose enable bit is low never sets its pending bit, however often it toggles. The enable is sampled in the cycle in which the synchronized transition is detected.
- R6: `irq_o` is high exactly when at least one code bit is set. Once high, it stays high until a read strobe clears the code.
- R7: While `code_rd_i` is high for one cycle, `code_o` still shows the pending bits. Every bit with no new event in that cycle is clear after the next clock edge.
- R8: A source event that arrives in the same cycle as `code_rd_i` leaves its bit set after the clear.
- R9: `stay_awake_o` is high whenever a code bit is set, or whenever a key pulse, an error pulse or an enabled pin transition is being taken in the current cycle. Otherwise it is low.
- R10: During reset, and right after it, `code_o` is zero and `irq_o` is low. The synchronizers reset to low, so pins should be low while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_evt_i | input | 1 | One-cycle pulse: a new key event was logged |
| err_evt_i | input | 1 | One-cycle pulse: an error was flagged |
| gpio_i | input | NUM_GPIO | Asynchronous general-purpose pins |
| gpio_irq_en_i | input | NUM_GPIO | Per-pin interrupt enable |
| code_rd_i | input | 1 | Host has read the interrupt code; clear at the next edge |
| code_o | output | NUM_GPIO+2 | Pending bits: bit0 key, bit1 error, bit 2+i pin i |
| irq_o | output | 1 | Interrupt request to the host, active high |
| stay_awake_o | output | 1 | Holds off low-power entry while anything is unresolved |

## Verification
The assertions check on every cycle the rules that hold step by step. A key or error pulse sets its bit. The request holds until a read. A read with no new events empties the code. A same-cycle event survives the clear. A disabled pin keeps its bit low. Stay-awake covers the request. Only the bench scenarios can show the three-cycle latency through the synchronizer for both edge directions, and that back-to-back toggles are all caught. They also show that the enable takes effect at the detect stage, and that long random mixes of reads and events keep the code correct against an independent cycle model.

// File: rtl/irq_pkg.sv
package irq_pkg;
    // Fixed positions of the sources inside the interrupt code
    localparam int KEY_BIT  = 0;
    localparam int ERR_BIT  = 1;
    localparam int PIN_BASE = 2;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int NUM_PINS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] en_i,
    output logic [NUM_PINS-1:0] edge_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] sync;
        logic [NUM_PINS-1:0] last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.sync = st_q.meta;
        st_d.last = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Either direction of a synchronized transition counts, masked by enable
    assign edge_o = (st_q.sync ^ st_q.last) & en_i;

    p_masked_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o & ~en_i) == '0);
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] pend_o
);
    typedef struct packed {
        logic [WIDTH-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.pend = '0;
        // New events win over the clear so none is lost
        st_d.pend = st_d.pend | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    p_set_survives_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((pend_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
    parameter int NUM_GPIO = 2,
    localparam int CODE_W  = NUM_GPIO + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                key_evt_i,
    input  logic                err_evt_i,
    input  logic [NUM_GPIO-1:0] gpio_i,
    input  logic [NUM_GPIO-1:0] gpio_irq_en_i,
    input  logic                code_rd_i,
    output logic [CODE_W-1:0]   code_o,
    output logic                irq_o,
    output logic                stay_awake_o
);
    import irq_pkg::*;

    logic [NUM_GPIO-1:0] pin_edge;
    logic [CODE_W-1:0]   set_vec;

    irq_edge_sync #(.NUM_PINS(NUM_GPIO)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (gpio_i),
        .en_i   (gpio_irq_en_i),
        .edge_o (pin_edge)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[KEY_BIT] = key_evt_i;
        set_vec[ERR_BIT] = err_evt_i;
        set_vec[PIN_BASE +: NUM_GPIO] = pin_edge;
    end

    irq_pend #(.WIDTH(CODE_W)) i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (code_rd_i),
        .pend_o (code_o)
    );

    assign irq_o        = |code_o;
    assign stay_awake_o = irq_o | (|set_vec);

    p_key_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        key_evt_i |=> (code_o[KEY_BIT] && irq_o));

    p_err_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt_i |=> (code_o[ERR_BIT] && irq_o));

    p_irq_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !code_rd_i) |=> irq_o);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_rd_i && !key_evt_i && !err_evt_i && !(|gpio_irq_en_i)) |=> !code_o[KEY_BIT] && !code_o[ERR_BIT]);

    p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_rd_i && key_evt_i) |=> code_o[KEY_BIT]);

    p_awake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> stay_awake_o);

    generate
        for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin_chk
            p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!gpio_irq_en_i[g] && !code_o[PIN_BASE+g]) |=> !code_o[PIN_BASE+g]);
        end
    endgenerate
endmodule

// File: tb/test_irq_collector.sv
module test_irq_collector;
    localparam int NG = 2;
    localparam int CW = NG + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_evt = 1'b0, err_evt = 1'b0, rd = 1'b0;
    logic [NG-1:0] pins = '0, en = '0;
    logic [CW-1:0] code;
    logic          irq, awake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [CW-1:0] exp_code = '0;
    logic [NG-1:0] h1 = '0, h2 = '0, h3 = '0;

    always #10 clk = ~clk;

    irq_collector #(.NUM_GPIO(NG)) i_irq_collector (
        .clk           (clk),
        .rst_n         (rst_n),
        .key_evt_i     (key_evt),
        .err_evt_i     (err_evt),
        .gpio_i        (pins),
        .gpio_irq_en_i (en),
        .code_rd_i     (rd),
        .code_o        (code),
        .irq_o         (irq),
        .stay_awake_o  (awake)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] set_of(input logic k, input logic e,
                                             input logic [NG-1:0] edg, input logic [NG-1:0] m);
        return {edg & m, e, k};
    endfunction

    // Called at a negedge: checks state, drives one cycle, advances the model
    task automatic step(input logic k, input logic e, input logic r,
                        input logic [NG-1:0] p, input logic [NG-1:0] m, input string req);
        logic [CW-1:0] s;
        chk(req, "code", 32'(code), 32'(exp_code));
        chk(req, "irq", 32'(irq), 32'(exp_code != '0));
        key_evt = k; err_evt = e; rd = r; pins = p; en = m;
        #1;
        s = set_of(k, e, h2 ^ h3, m);
        chk(req, "awake", 32'(awake), 32'((exp_code != '0) || (s != '0)));
        @(posedge clk);
        exp_code = (r ? '0 : exp_code) | s;
        h3 = h2; h2 = h1; h1 = p;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, pins, en, req);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        chk("R10", "code in reset", 32'(code), 32'h0);
        chk("R10", "irq in reset", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "awake after reset", 32'(awake), 32'h0);
        idle(2, "R10");

        // R1: key pulse, request holds (R6), then read clears (R7)
        step(1'b1, 1'b0, 1'b0, '0, '0, "R1");
        idle(4, "R6");
        step(1'b0, 1'b0, 1'b1, '0, '0, "R7");
        idle(2, "R7");
        chk("R9", "awake idle", 32'(awake), 32'h0);

        // R2: error pulse
        step(1'b0, 1'b1, 1'b0, '0, '0, "R2");
        idle(2, "R2");
        step(1'b0, 1'b0, 1'b1, '0, '0, "R7");

        // R3: rising edge on enabled pin 0
        step(1'b0, 1'b0, 1'b0, 2'b01, 2'b11, "R3");
        idle(4, "R3");
        chk("R3", "pin0 bit", 32'(code[2]), 32'h1);
        step(1'b0, 1'b0, 1'b1, pins, en, "R7");
        // R4: falling edge on pin 0, rising on pin 1
        step(1'b0, 1'b0, 1'b0, 2'b10, 2'b11, "R4");
        idle(4, "R4");
        chk("R4", "both pin bits", 32'(code[3:2]), 32'h3);
        step(1'b0, 1'b0, 1'b1, pins, en, "R7");

        // R5: toggling with enables low
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, ~pins, 2'b00, "R5");
        idle(4, "R5");
        chk("R5", "pin bits stay low", 32'(code[3:2]), 32'h0);

        // R8: key and error in the read cycle survive the clear
        step(1'b1, 1'b0, 1'b0, pins, 2'b00, "R8");
        step(1'b1, 1'b1, 1'b1, pins, 2'b00, "R8");
        chk("R8", "bits kept", 32'(code[1:0]), 32'h3);
        idle(1, "R8");
        step(1'b0, 1'b0, 1'b1, pins, 2'b00, "R7");
        // R9: live event raises awake with nothing pending
        step(1'b0, 1'b1, 1'b0, pins, 2'b00, "R9");
        step(1'b0, 1'b0, 1'b1, pins, 2'b00, "R7");
        idle(3, "R9");

        // Random mix against the cycle model
        for (int i = 0; i < 3000; i++) begin
            logic k, e, r;
            logic [NG-1:0] p, m;
            k = ($urandom % 8) == 0;
            e = ($urandom % 16) == 0;
            r = ($urandom % 5) == 0;
            p = (($urandom % 3) == 0) ? NG'($urandom) : pins;
            m = (($urandom % 10) == 0) ? NG'($urandom) : en;
            step(k, e, r, p, m, "R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule